// File: doc/BRIEF.md
# Video Frame Timing and Activity Monitor

This block observes three start-of-frame strobes: one from a video input stream, one from a video output stream and one from a processing engine. At each of the three points it counts the frames that begin and measures how many clock cycles separate the two most recent frame starts. The engine also has a done strobe. From it the block derives how long the engine was busy on its last frame and how far the engine start trailed the latest input frame start. A sticky flag records any frame that the engine did not finish before the next one began.

Software reads the results over a small synchronous read port, with one cycle of latency. Every measurement is latched when its event occurs, so a read always returns the last complete value and never a count still in progress. Running counters stop at all-ones and do not wrap. Every input belongs to a single clock domain.

Top module: `vfmon_top`

## Requirements
- R1: After reset, every mapped address reads 0. The overrun flag reads 0.
- R2: Each frame counter (input at address 0, output at 2, engine at 4) increases by one on each cycle in which its strobe is high. This holds whether or not the frame later completes.
- R3: The period registers (input at 1, output at 3, engine at 5) hold the cycle distance between the two most recent strobes at their point. A period register stays 0 until two strobes have been seen, and it holds its value between strobes.
- R4: Frame counts, periods, busy times and delays saturate at the all-ones value of the counter width. They do not wrap.
- R5: When the engine signals done while a frame is active, the busy register (address 6) takes the number of cycles from the engine start to the done cycle, and the frame ends. If done and a new engine start arrive in the same cycle, done wins: the frame completes and the new one begins.
- R6: If an engine start arrives while a frame is active and done is not high, the busy register takes the cycles since the earlier start and the overrun flag (address 8, bit 0) is set.
- R7: At each engine start, the delay register (address 7) takes the cycles since the latest input strobe. It takes 0 if both strobes fall in the same cycle. It keeps its value if no input strobe has yet been seen.
- R8: A read of address 8 returns the flag and clears it. If the flag is set in the same cycle as that read, the flag stays set.
- R9: Data appears on the read port one cycle after the read enable. Values are zero-extended to 32 bits. Unmapped addresses (9 to 15) read 0. The read data holds its value while the read enable is low.
- R10: A done strobe while no engine frame is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sof | input | 1 | Input stream frame start strobe |
| out_sof | input | 1 | Output stream frame start strobe |
| eng_sof | input | 1 | Engine frame start strobe |
| eng_done | input | 1 | Engine frame completion strobe |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 4 | Register word address |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with an 8-bit counter width. At that width saturation at 255 takes only a few hundred cycles, so saturation of the frame counter, the period, the busy time and the delay is exercised directly. The bench sweeps periods, busy times and delays over several gaps at all three points, and it checks every address, including the unmapped ones. The same small width lets the bench hit the ordering cases: done coinciding with a new start, and a flag set coinciding with the read that clears it.

// File: rtl/vfm_pkg.sv
package vfm_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int NPOINT = 3;
  localparam int NREG   = 9;

  typedef enum logic [ADDR_W-1:0] {
    SEL_IN_CNT   = 4'd0,
    SEL_IN_PER   = 4'd1,
    SEL_OUT_CNT  = 4'd2,
    SEL_OUT_PER  = 4'd3,
    SEL_ENG_CNT  = 4'd4,
    SEL_ENG_PER  = 4'd5,
    SEL_ENG_BUSY = 4'd6,
    SEL_ENG_DLY  = 4'd7,
    SEL_ENG_FAIL = 4'd8
  } reg_sel_e;

  // index of each strobe in the point array
  localparam int PT_IN  = 0;
  localparam int PT_OUT = 1;
  localparam int PT_ENG = 2;
endpackage

// File: rtl/vfm_point.sv
module vfm_point #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] since,
  output logic             seen
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             seen_q, seen_d;

  always_comb begin
    cnt_d  = cnt_q;
    run_d  = run_q;
    per_d  = per_q;
    seen_d = seen_q | sof;
    if (sof && (cnt_q != MAXV)) cnt_d = cnt_q + ONE;
    if (sof) begin
      run_d = ONE;
      if (seen_q) per_d = run_q;
    end else if (seen_q && (run_q != MAXV)) begin
      run_d = run_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      run_q  <= '0;
      per_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_d;
      per_q  <= per_d;
      seen_q <= seen_d;
    end
  end

  assign count  = cnt_q;
  assign period = per_q;
  assign since  = run_q;
  assign seen   = seen_q;
endmodule

// File: rtl/vfm_engine.sv
module vfm_engine #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eng_sof,
  input  logic             eng_done,
  input  logic             in_sof,
  input  logic [CNT_W-1:0] in_since,
  input  logic             in_seen,
  input  logic             fail_clr,
  output logic [CNT_W-1:0] busy,
  output logic [CNT_W-1:0] delay,
  output logic             fail,
  output logic             active
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             act_q, act_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] busy_q, busy_d;
  logic [CNT_W-1:0] dly_q, dly_d;
  logic             fail_q, fail_d;
  logic             fail_set;
  logic             frame_end;

  assign frame_end = act_q && (eng_done || eng_sof);
  assign fail_set  = eng_sof && act_q && !eng_done;

  always_comb begin
    act_d  = act_q;
    run_d  = run_q;
    busy_d = busy_q;
    dly_d  = dly_q;
    if (frame_end) busy_d = run_q;
    if (eng_sof) begin
      act_d = 1'b1;
      run_d = ONE;
      if (in_sof)       dly_d = '0;
      else if (in_seen) dly_d = in_since;
    end else if (act_q && eng_done) begin
      act_d = 1'b0;
    end else if (act_q && (run_q != MAXV)) begin
      run_d = run_q + ONE;
    end
    fail_d = fail_set | (fail_q & ~fail_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      run_q  <= '0;
      busy_q <= '0;
      dly_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      run_q  <= run_d;
      busy_q <= busy_d;
      dly_q  <= dly_d;
      fail_q <= fail_d;
    end
  end

  assign busy   = busy_q;
  assign delay  = dly_q;
  assign fail   = fail_q;
  assign active = act_q;
endmodule

// File: rtl/vfm_regs.sv
module vfm_regs
  import vfm_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         rd_en,
  input  logic [ADDR_W-1:0]            rd_addr,
  input  logic [NREG-1:0][DATA_W-1:0]  words,
  output logic                         fail_clr,
  output logic [DATA_W-1:0]            rd_data
);
  logic [DATA_W-1:0] sel_word;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    sel_word = '0;
    for (int k = 0; k < NREG; k++) begin
      if (rd_addr == ADDR_W'(k)) sel_word = words[k];
    end
    data_d = rd_en ? sel_word : data_q;
  end

  assign fail_clr = rd_en && (rd_addr == SEL_ENG_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;
endmodule

// File: rtl/vfmon_top.sv
module vfmon_top
  import vfm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_sof,
  input  logic              out_sof,
  input  logic              eng_sof,
  input  logic              eng_done,
  input  logic              rd_en,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data
);
  logic [NPOINT-1:0]            sof_v;
  logic [NPOINT-1:0][CNT_W-1:0] cnt_a;
  logic [NPOINT-1:0][CNT_W-1:0] per_a;
  logic [NPOINT-1:0][CNT_W-1:0] since_a;
  logic [NPOINT-1:0]            seen_a;
  logic [CNT_W-1:0]             busy_v;
  logic [CNT_W-1:0]             dly_v;
  logic                         fail_v;
  logic                         eng_active;
  logic                         fail_clr;
  logic [NREG-1:0][DATA_W-1:0]  words;

  assign sof_v[PT_IN]  = in_sof;
  assign sof_v[PT_OUT] = out_sof;
  assign sof_v[PT_ENG] = eng_sof;

  for (genvar p = 0; p < NPOINT; p++) begin : g_pt
    vfm_point #(.CNT_W(CNT_W)) u_pt (
      .clk    (clk),
      .rst_n  (rst_n),
      .sof    (sof_v[p]),
      .count  (cnt_a[p]),
      .period (per_a[p]),
      .since  (since_a[p]),
      .seen   (seen_a[p])
    );
    assign words[2*p]   = DATA_W'(cnt_a[p]);
    assign words[2*p+1] = DATA_W'(per_a[p]);
  end

  vfm_engine #(.CNT_W(CNT_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .eng_sof  (eng_sof),
    .eng_done (eng_done),
    .in_sof   (in_sof),
    .in_since (since_a[PT_IN]),
    .in_seen  (seen_a[PT_IN]),
    .fail_clr (fail_clr),
    .busy     (busy_v),
    .delay    (dly_v),
    .fail     (fail_v),
    .active   (eng_active)
  );

  assign words[SEL_ENG_BUSY] = DATA_W'(busy_v);
  assign words[SEL_ENG_DLY]  = DATA_W'(dly_v);
  assign words[SEL_ENG_FAIL] = DATA_W'(fail_v);

  vfm_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .words    (words),
    .fail_clr (fail_clr),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/vfm_chk.sv
module vfm_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_sof,
  input logic             eng_sof,
  input logic             eng_done,
  input logic             rd_en,
  input logic [3:0]       rd_addr,
  input logic [31:0]      rd_data,
  input logic [CNT_W-1:0] in_cnt,
  input logic [CNT_W-1:0] busy,
  input logic             fail,
  input logic             eng_active
);
  // R2
  in_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sof && (in_cnt != {CNT_W{1'b1}})) |=> (in_cnt == $past(in_cnt) + CNT_W'(1)));
  // R2
  in_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sof |=> $stable(in_cnt));
  // R4
  in_cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt == {CNT_W{1'b1}}) |=> (in_cnt == {CNT_W{1'b1}}));
  // R6
  fail_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_sof && eng_active && !eng_done) |=> fail);
  // R8
  fail_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == 4'd8) && !(eng_sof && eng_active && !eng_done)) |=> !fail);
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
  // R10
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !eng_active && !eng_sof) |=> $stable(busy));
endmodule

bind vfmon_top vfm_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_sof     (in_sof),
  .eng_sof    (eng_sof),
  .eng_done   (eng_done),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .in_cnt     (cnt_a[0]),
  .busy       (busy_v),
  .fail       (fail_v),
  .eng_active (eng_active)
);

// File: tb/vfmon_top_tb_top.sv
module vfmon_top_tb_top;
  localparam int CW   = 8;
  localparam int MAXV = 255;

  logic        clk;
  logic        rst_n;
  logic        in_sof, out_sof, eng_sof, eng_done, rd_en;
  logic [3:0]  rd_addr;
  logic [31:0] rd_data;

  int n_chk;
  int n_bad;
  int cnt_m [3];
  bit finished;

  vfmon_top #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .out_sof(out_sof),
    .eng_sof(eng_sof), .eng_done(eng_done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int sat(input int v);
    return (v > MAXV) ? MAXV : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock edge with the given strobes; returns at the following negedge
  task automatic cyc(input logic i, input logic o, input logic e, input logic d,
                     input logic re, input logic [3:0] a);
    in_sof = i; out_sof = o; eng_sof = e; eng_done = d; rd_en = re; rd_addr = a;
    @(posedge clk);
    if (i) cnt_m[0] = sat(cnt_m[0] + 1);
    if (o) cnt_m[1] = sat(cnt_m[1] + 1);
    if (e) cnt_m[2] = sat(cnt_m[2] + 1);
    @(negedge clk);
    in_sof = 0; out_sof = 0; eng_sof = 0; eng_done = 0; rd_en = 0; rd_addr = 4'd0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, 4'd0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    cyc(0, 0, 0, 0, 1, a);
    v = rd_data;
  endtask

  task automatic pulse(input int p);
    cyc(p == 0, p == 1, p == 2, 0, 0, 4'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int gaps [5] = '{1, 2, 3, 7, 20};
    int bts  [4] = '{1, 2, 4, 9};
    int dls  [3] = '{0, 3, 10};
    n_chk = 0; n_bad = 0; finished = 0;
    for (int k = 0; k < 3; k++) cnt_m[k] = 0;
    in_sof = 0; out_sof = 0; eng_sof = 0; eng_done = 0; rd_en = 0; rd_addr = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values, R9 unmapped addresses
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk((a < 9) ? "R1 reset" : "R9 unmapped", v, 0);
    end

    // R7 delay held when no input frame seen; R5 busy of one cycle
    cyc(0, 0, 1, 0, 0, 4'd0);
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd7, v); chk("R7 no input", v, 0);
    rd(4'd6, v); chk("R5 busy 1", v, 1);

    // R3 single strobe leaves period 0
    pulse(0);
    rd(4'd1, v); chk("R3 one strobe", v, 0);

    // R3 period sweep at each point, R6 overrun on engine
    for (int p = 0; p < 3; p++) begin
      foreach (gaps[g]) begin
        pulse(p);
        idle(gaps[g] - 1);
        pulse(p);
        rd(4'(2*p + 1), v); chk("R3 period", v, gaps[g]);
        rd(4'(2*p), v);     chk("R2 count", v, cnt_m[p]);
        if (p == 2) begin
          rd(4'd6, v); chk("R6 busy at restart", v, gaps[g]);
          rd(4'd8, v); chk("R6 flag", v, 1);
          rd(4'd8, v); chk("R8 cleared", v, 0);
        end
      end
    end

    // R4 period saturation
    pulse(1);
    idle(300);
    pulse(1);
    rd(4'd3, v); chk("R4 period sat", v, MAXV);

    // R4 count saturation on input
    for (int k = 0; k < 260; k++) pulse(0);
    rd(4'd0, v); chk("R4 count sat", v, MAXV);
    rd(4'd1, v); chk("R3 back to back", v, 1);

    // close engine frame, clear flag
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd8, v);

    // R5 busy sweep
    foreach (bts[b]) begin
      cyc(0, 0, 1, 0, 0, 4'd0);
      idle(bts[b] - 1);
      cyc(0, 0, 0, 1, 0, 4'd0);
      rd(4'd6, v); chk("R5 busy", v, bts[b]);
      rd(4'd8, v); chk("R5 no flag", v, 0);
    end

    // R5 done and new start in the same cycle
    cyc(0, 0, 1, 0, 0, 4'd0);
    idle(3);
    cyc(0, 0, 1, 1, 0, 4'd0);
    idle(1);
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd6, v); chk("R5 restart busy", v, 2);
    rd(4'd8, v); chk("R5 done wins", v, 0);

    // R10 idle done ignored
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd6, v); chk("R10 idle done", v, 2);

    // R8 set wins over clear
    cyc(0, 0, 1, 0, 0, 4'd0);
    idle(2);
    cyc(0, 0, 1, 0, 1, 4'd8);
    chk("R8 old value", rd_data, 0);
    rd(4'd8, v); chk("R8 set wins", v, 1);
    rd(4'd8, v); chk("R8 cleared", v, 0);
    cyc(0, 0, 0, 1, 0, 4'd0);

    // R7 delay sweep
    foreach (dls[d]) begin
      cyc(1, 0, 0, 0, 0, 4'd0);
      idle(dls[d]);
      cyc(0, 0, 1, 0, 0, 4'd0);
      cyc(0, 0, 0, 1, 0, 4'd0);
      rd(4'd7, v); chk("R7 delay", v, dls[d] + 1);
    end
    cyc(1, 0, 1, 0, 0, 4'd0);
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd7, v); chk("R7 same cycle", v, 0);

    // R4 delay and busy saturation
    cyc(1, 0, 0, 0, 0, 4'd0);
    idle(300);
    cyc(0, 0, 1, 0, 0, 4'd0);
    idle(300);
    cyc(0, 0, 0, 1, 0, 4'd0);
    rd(4'd7, v); chk("R4 delay sat", v, MAXV);
    rd(4'd6, v); chk("R4 busy sat", v, MAXV);

    // R2 final counts; R9 hold while idle
    rd(4'd4, v); chk("R2 engine count", v, cnt_m[2]);
    rd(4'd2, v); chk("R2 output count", v, cnt_m[1]);
    idle(4);
    chk("R9 hold", rd_data, v);

    finish_run();
  end
endmodule